// File: doc/BRIEF.md
# Multi-controller inbound DMA window decoder

This block sits on the inbound path of a PCIe controller and turns a PCIe-side DMA address into a system-memory address. System memory can be spread over one to three memory controllers. Each controller is reached through its own viewport. Each viewport has a power-of-two size and holds a base region, optionally followed by an extension region. The two regions sit apart in physical memory, but they appear back to back inside the viewport. The viewports are packed in controller order, starting at a programmable window offset. The whole inbound window is the sum of the active viewports, rounded up to a power of two.

Configuration arrives as static inputs: the number of controllers, the sizes of each viewport, base region and extension region, the physical bases of both regions, and the window offset. An automatic mode is also available. It uses a single controller whose viewport is the size of that controller's base and extension regions together, rounded up to a power of two. Each valid address produces a registered result one cycle later. The result is either a hit, with the controller index, the region and the physical address, or a miss. A configuration-error flag reports viewport settings that cannot work.

Top module: `dmawin_decoder`

## Requirements
- R1: While reset is active and after it, until the first valid address, out_valid, out_hit, out_miss, out_ext, out_ctrl, out_phys and cfg_err are all zero.
- R2: win_size equals the sum of the active viewport sizes, rounded up to the next power of two. A sum that is already a power of two is kept unchanged.
- R3: An address below cfg_win_base, or at or above cfg_win_base + win_size, gives out_miss=1 and out_hit=0.
- R4: Viewports are adjacent in controller index order. Controller i's viewport starts at cfg_win_base plus the sizes of viewports 0..i-1, and out_ctrl reports i for addresses inside it.
- R5: An address at offset off inside a viewport, with off below that controller's base size, gives out_ext=0 and out_phys = base_phys + off.
- R6: The extension region follows the base region directly. For base_size <= off < base_size + ext_size, the result is out_ext=1 and out_phys = ext_phys + (off - base_size).
- R7: An address inside the window that falls past the last active viewport, or past base_size + ext_size inside its viewport, is a miss.
- R8: With cfg_auto=1, only controller 0 is used, with a viewport of pow2ceil(base_size0 + ext_size0). cfg_count is ignored, and cfg_err is not raised by viewport settings.
- R9: With cfg_auto=0, cfg_err=1 (one cycle after the settings) in any of these cases: an active viewport size is not a power of two, an active viewport is smaller than its base plus extension size, or cfg_count is 0 or greater than the number of controllers.
- R10: out_valid follows in_valid by exactly one cycle. When out_valid=1, exactly one of out_hit and out_miss is set. On a cycle without a valid input, out_ctrl, out_ext and out_phys keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_auto | input | 1 | Single-controller automatic sizing mode |
| cfg_count | input | CNT_W (2) | Number of active controllers |
| cfg_win_base | input | ADDR_W | Lowest PCIe address of the window |
| cfg_vp_size | input | NUM_MC*ADDR_W | Viewport sizes; controller i in bits [i*ADDR_W +: ADDR_W] |
| cfg_base_size | input | NUM_MC*ADDR_W | Base region sizes, same packing |
| cfg_ext_size | input | NUM_MC*ADDR_W | Extension region sizes, same packing |
| cfg_base_phys | input | NUM_MC*ADDR_W | Physical start addresses of the base regions |
| cfg_ext_phys | input | NUM_MC*ADDR_W | Physical start addresses of the extension regions |
| in_valid | input | 1 | Address strobe |
| in_addr | input | ADDR_W | Inbound PCIe address |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_hit | output | 1 | Address was translated |
| out_miss | output | 1 | Address was rejected |
| out_ctrl | output | SEL_W (2) | Selected controller index |
| out_ext | output | 1 | 0 = base region, 1 = extension region |
| out_phys | output | ADDR_W | Translated physical address |
| win_size | output | ADDR_W+2 | Overall window size |
| cfg_err | output | 1 | Configuration error |

## Verification
A wrong start offset in the cumulative viewport table would move the controller boundaries. It shows up one cycle after the first address near a boundary, as a wrong out_ctrl or as a hit that should be a miss. A wrong rounding result shows up on win_size one cycle after the configuration changes. It also moves the upper window edge, so an address just past the window flips between hit and miss. A region split error would show up as a wrong out_ext, or as an out_phys that is off by exactly the base size. The tests place addresses on both sides of each such edge.

// File: rtl/dmawin_pkg.sv
package dmawin_pkg;
  typedef enum logic {
    REGION_BASE = 1'b0,
    REGION_EXT  = 1'b1
  } region_e;
endpackage

// File: rtl/dmawin_cfg.sv
module dmawin_cfg #(
  parameter int ADDR_W = 32,
  parameter int NUM_MC = 3,
  parameter int CNT_W  = 2,
  parameter int SUM_W  = ADDR_W + 2
) (
  input  logic                     cfg_auto,
  input  logic [CNT_W-1:0]         cfg_count,
  input  logic [NUM_MC*ADDR_W-1:0] cfg_vp_size,
  input  logic [NUM_MC*ADDR_W-1:0] cfg_base_size,
  input  logic [NUM_MC*ADDR_W-1:0] cfg_ext_size,
  output logic [NUM_MC*SUM_W-1:0]  vp_eff,
  output logic [NUM_MC*SUM_W-1:0]  vp_start,
  output logic [NUM_MC-1:0]        vp_active,
  output logic [SUM_W-1:0]         win_total,
  output logic                     err
);

  function automatic logic [SUM_W-1:0] pow2ceil(input logic [SUM_W-1:0] v);
    logic [SUM_W-1:0] m;
    if (v <= 1) return 1;
    m = v - 1'b1;
    for (int k = 1; k < SUM_W; k = k * 2) m = m | (m >> k);
    return m + 1'b1;
  endfunction

  function automatic logic is_pow2(input logic [ADDR_W-1:0] v);
    return (v != '0) && ((v & (v - 1'b1)) == '0);
  endfunction

  logic             count_bad;
  logic [CNT_W-1:0] count_eff;
  logic [SUM_W-1:0] sum_acc;
  logic [SUM_W-1:0] region_need [NUM_MC];
  logic [NUM_MC-1:0] size_bad;

  assign count_bad = (cfg_count == '0) || (cfg_count > CNT_W'(NUM_MC));

  always_comb begin
    if (cfg_auto || cfg_count == '0) count_eff = CNT_W'(1);
    else if (cfg_count > CNT_W'(NUM_MC)) count_eff = CNT_W'(NUM_MC);
    else count_eff = cfg_count;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_MC; g++) begin : g_need
      assign region_need[g] = SUM_W'(cfg_base_size[g*ADDR_W +: ADDR_W])
                            + SUM_W'(cfg_ext_size[g*ADDR_W +: ADDR_W]);
      assign vp_active[g]   = (CNT_W'(g) < count_eff);
      assign size_bad[g]    = vp_active[g] &&
                              (!is_pow2(cfg_vp_size[g*ADDR_W +: ADDR_W]) ||
                               SUM_W'(cfg_vp_size[g*ADDR_W +: ADDR_W]) < region_need[g]);
      always_comb begin
        if (!vp_active[g])
          vp_eff[g*SUM_W +: SUM_W] = '0;
        else if (cfg_auto)
          vp_eff[g*SUM_W +: SUM_W] = pow2ceil(region_need[g]);
        else
          vp_eff[g*SUM_W +: SUM_W] = SUM_W'(cfg_vp_size[g*ADDR_W +: ADDR_W]);
      end
    end
  endgenerate

  always_comb begin
    sum_acc = '0;
    for (int i = 0; i < NUM_MC; i++) begin
      vp_start[i*SUM_W +: SUM_W] = sum_acc;
      sum_acc = sum_acc + vp_eff[i*SUM_W +: SUM_W];
    end
  end

  assign win_total = pow2ceil(sum_acc);
  assign err       = !cfg_auto && (count_bad || (|size_bad));

endmodule

// File: rtl/dmawin_slot.sv
module dmawin_slot #(
  parameter int ADDR_W = 32,
  parameter int SUM_W  = ADDR_W + 2
) (
  input  logic [SUM_W-1:0]  rel,
  input  logic [SUM_W-1:0]  start,
  input  logic [SUM_W-1:0]  span,
  input  logic              active,
  input  logic [ADDR_W-1:0] base_size,
  input  logic [ADDR_W-1:0] ext_size,
  input  logic [ADDR_W-1:0] base_phys,
  input  logic [ADDR_W-1:0] ext_phys,
  output logic              claim,
  output logic              mapped,
  output dmawin_pkg::region_e region,
  output logic [ADDR_W-1:0] phys
);
  import dmawin_pkg::*;

  logic [SUM_W-1:0] off;
  logic [SUM_W-1:0] base_end;
  logic [SUM_W-1:0] ext_off;

  assign off      = rel - start;
  assign base_end = SUM_W'(base_size);
  assign ext_off  = off - base_end;
  assign claim    = active && (rel >= start) && (off < span);
  assign mapped   = claim && (off < base_end + SUM_W'(ext_size));

  always_comb begin
    if (off < base_end) begin
      region = REGION_BASE;
      phys   = base_phys + off[ADDR_W-1:0];
    end else begin
      region = REGION_EXT;
      phys   = ext_phys + ext_off[ADDR_W-1:0];
    end
  end

endmodule

// File: rtl/dmawin_decoder.sv
module dmawin_decoder #(
  parameter int ADDR_W = 32,
  parameter int NUM_MC = 3,
  parameter int CNT_W  = $clog2(NUM_MC + 1),
  parameter int SEL_W  = (NUM_MC > 1) ? $clog2(NUM_MC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_auto,
  input  logic [CNT_W-1:0]         cfg_count,
  input  logic [ADDR_W-1:0]        cfg_win_base,
  input  logic [NUM_MC*ADDR_W-1:0] cfg_vp_size,
  input  logic [NUM_MC*ADDR_W-1:0] cfg_base_size,
  input  logic [NUM_MC*ADDR_W-1:0] cfg_ext_size,
  input  logic [NUM_MC*ADDR_W-1:0] cfg_base_phys,
  input  logic [NUM_MC*ADDR_W-1:0] cfg_ext_phys,
  input  logic                     in_valid,
  input  logic [ADDR_W-1:0]        in_addr,
  output logic                     out_valid,
  output logic                     out_hit,
  output logic                     out_miss,
  output logic [SEL_W-1:0]         out_ctrl,
  output logic                     out_ext,
  output logic [ADDR_W-1:0]        out_phys,
  output logic [ADDR_W+1:0]        win_size,
  output logic                     cfg_err
);
  import dmawin_pkg::*;

  localparam int SUM_W = ADDR_W + 2;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  logic [NUM_MC*SUM_W-1:0] vp_eff, vp_start;
  logic [NUM_MC-1:0]       vp_active;
  logic [SUM_W-1:0]        win_total;
  logic                    err_c;

  dmawin_cfg #(.ADDR_W(ADDR_W), .NUM_MC(NUM_MC), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_cfg (
    .cfg_auto      (cfg_auto),
    .cfg_count     (cfg_count),
    .cfg_vp_size   (cfg_vp_size),
    .cfg_base_size (cfg_base_size),
    .cfg_ext_size  (cfg_ext_size),
    .vp_eff        (vp_eff),
    .vp_start      (vp_start),
    .vp_active     (vp_active),
    .win_total     (win_total),
    .err           (err_c)
  );

  logic             below;
  logic [SUM_W-1:0] rel;
  logic             in_win;
  assign below  = in_addr < cfg_win_base;
  assign rel    = SUM_W'(in_addr) - SUM_W'(cfg_win_base);
  assign in_win = !below && (rel < win_total);

  logic [NUM_MC-1:0] s_claim, s_mapped;
  region_e           s_region [NUM_MC];
  logic [ADDR_W-1:0] s_phys   [NUM_MC];

  genvar g;
  generate
    for (g = 0; g < NUM_MC; g++) begin : g_slot
      dmawin_slot #(.ADDR_W(ADDR_W), .SUM_W(SUM_W)) u_slot (
        .rel       (rel),
        .start     (vp_start[g*SUM_W +: SUM_W]),
        .span      (vp_eff[g*SUM_W +: SUM_W]),
        .active    (vp_active[g]),
        .base_size (cfg_base_size[g*ADDR_W +: ADDR_W]),
        .ext_size  (cfg_ext_size[g*ADDR_W +: ADDR_W]),
        .base_phys (cfg_base_phys[g*ADDR_W +: ADDR_W]),
        .ext_phys  (cfg_ext_phys[g*ADDR_W +: ADDR_W]),
        .claim     (s_claim[g]),
        .mapped    (s_mapped[g]),
        .region    (s_region[g]),
        .phys      (s_phys[g])
      );
    end
  endgenerate

  // next-state
  logic              hit_c;
  logic [SEL_W-1:0]  ctrl_c;
  logic              ext_c;
  logic [ADDR_W-1:0] phys_c;

  always_comb begin
    hit_c  = 1'b0;
    ctrl_c = '0;
    ext_c  = 1'b0;
    phys_c = '0;
    for (int i = NUM_MC - 1; i >= 0; i--) begin
      if (s_claim[i]) begin
        hit_c  = in_win && s_mapped[i];
        ctrl_c = SEL_W'(i);
        ext_c  = (s_region[i] == REGION_EXT);
        phys_c = s_phys[i];
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_miss  <= 1'b0;
      out_ctrl  <= '0;
      out_ext   <= 1'b0;
      out_phys  <= '0;
      win_size  <= '0;
      cfg_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_hit   <= in_valid && hit_c;
      out_miss  <= in_valid && !hit_c;
      win_size  <= win_total;
      cfg_err   <= err_c;
      if (in_valid) begin
        out_ctrl <= ctrl_c;
        out_ext  <= ext_c;
        out_phys <= phys_c;
      end
    end
  end

endmodule

// File: rtl/dmawin_decoder_chk.sv
module dmawin_decoder_chk #(
  parameter int ADDR_W = 32,
  parameter int NUM_MC = 3,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic [ADDR_W-1:0] cfg_win_base,
  input logic              out_valid,
  input logic              out_hit,
  input logic              out_miss,
  input logic [SEL_W-1:0]  out_ctrl,
  input logic              out_ext,
  input logic [ADDR_W-1:0] out_phys,
  input logic [ADDR_W+1:0] win_size
);

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_one_verdict_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hit ^ out_miss));

  assert_no_stray_verdict_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(out_hit || out_miss));

  assert_payload_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_phys) && $stable(out_ctrl) && $stable(out_ext)));

  assert_below_misses_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_addr < cfg_win_base)) |=> out_miss);

  assert_window_pow2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(win_size) == 1));

  assert_ctrl_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> (int'(out_ctrl) < NUM_MC));

endmodule

bind dmawin_decoder dmawin_decoder_chk #(.ADDR_W(ADDR_W), .NUM_MC(NUM_MC), .SEL_W(SEL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sn),
  .in_valid     (in_valid),
  .in_addr      (in_addr),
  .cfg_win_base (cfg_win_base),
  .out_valid    (out_valid),
  .out_hit      (out_hit),
  .out_miss     (out_miss),
  .out_ctrl     (out_ctrl),
  .out_ext      (out_ext),
  .out_phys     (out_phys),
  .win_size     (win_size)
);

// File: tb/dmawin_decoder_test.sv
module dmawin_decoder_test;
  localparam int AW = 32;
  localparam int NM = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_auto;
  logic [1:0]      cfg_count;
  logic [AW-1:0]   cfg_win_base;
  logic [NM*AW-1:0] cfg_vp_size, cfg_base_size, cfg_ext_size, cfg_base_phys, cfg_ext_phys;
  logic            in_valid;
  logic [AW-1:0]   in_addr;
  logic            out_valid, out_hit, out_miss, out_ext, cfg_err;
  logic [1:0]      out_ctrl;
  logic [AW-1:0]   out_phys;
  logic [AW+1:0]   win_size;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dmawin_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_auto(cfg_auto), .cfg_count(cfg_count),
    .cfg_win_base(cfg_win_base), .cfg_vp_size(cfg_vp_size), .cfg_base_size(cfg_base_size),
    .cfg_ext_size(cfg_ext_size), .cfg_base_phys(cfg_base_phys), .cfg_ext_phys(cfg_ext_phys),
    .in_valid(in_valid), .in_addr(in_addr), .out_valid(out_valid), .out_hit(out_hit),
    .out_miss(out_miss), .out_ctrl(out_ctrl), .out_ext(out_ext), .out_phys(out_phys),
    .win_size(win_size), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic base_cfg();
    cfg_auto     = 1'b0;
    cfg_count    = 2'd3;
    cfg_win_base = 32'h4000_0000;
    cfg_vp_size   = {32'h0400_0000, 32'h0800_0000, 32'h1000_0000};
    cfg_base_size = {32'h0100_0000, 32'h0800_0000, 32'h0C00_0000};
    cfg_ext_size  = {32'h0100_0000, 32'h0000_0000, 32'h0200_0000};
    cfg_base_phys = {32'hA000_0000, 32'h9000_0000, 32'h8000_0000};
    cfg_ext_phys  = {32'hB000_0000, 32'h0000_0000, 32'h2000_0000};
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  // drive one address at a negedge, sample the result at the following negedge
  task automatic lookup(input logic [AW-1:0] a);
    in_valid = 1'b1;
    in_addr  = a;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_hit(input string req, input logic [AW-1:0] a,
                            input logic [1:0] c, input logic e, input logic [AW-1:0] p);
    lookup(a);
    check(out_valid && out_hit && !out_miss, req, {63'd0, out_hit}, 64'd1);
    check(out_ctrl == c, req, 64'(out_ctrl), 64'(c));
    check(out_ext == e, req, 64'(out_ext), 64'(e));
    check(out_phys == p, req, 64'(out_phys), 64'(p));
  endtask

  task automatic expect_miss(input string req, input logic [AW-1:0] a);
    lookup(a);
    check(out_valid && out_miss && !out_hit, req, {62'd0, out_miss, out_hit}, 64'd2);
  endtask

  task automatic t_reset_R1();
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_addr = '0;
    base_cfg();
    repeat (3) @(negedge clk);
    check(!out_valid && !out_hit && !out_miss && !out_ext && out_ctrl == 0 &&
          out_phys == 0 && !cfg_err, "R1", 64'(out_phys), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!out_valid && !out_hit && !out_miss && out_phys == 0 && !cfg_err,
          "R1", 64'(out_valid), 64'd0);
  endtask

  task automatic t_size_R2();
    base_cfg();
    settle();
    check(win_size == 34'h0_2000_0000, "R2", 64'(win_size), 64'h2000_0000);
    cfg_count = 2'd2;
    settle();
    check(win_size == 34'h0_2000_0000, "R2", 64'(win_size), 64'h2000_0000);
    cfg_count = 2'd1;
    settle();
    check(win_size == 34'h0_1000_0000, "R2 exact", 64'(win_size), 64'h1000_0000);
    expect_miss("R3 end single", 32'h5000_0000);
    base_cfg();
    settle();
  endtask

  task automatic t_edges_R3();
    expect_miss("R3 below", 32'h3FFF_FFFF);
    expect_miss("R3 at end", 32'h6000_0000);
    expect_hit("R3 first", 32'h4000_0000, 2'd0, 1'b0, 32'h8000_0000);
  endtask

  task automatic t_map_R4_R5_R6();
    expect_hit("R5 c0 base", 32'h4000_0010, 2'd0, 1'b0, 32'h8000_0010);
    expect_hit("R6 c0 ext", 32'h4C00_0004, 2'd0, 1'b1, 32'h2000_0004);
    expect_hit("R4 c1", 32'h5000_0100, 2'd1, 1'b0, 32'h9000_0100);
    expect_hit("R4 c2 base", 32'h5800_0000, 2'd2, 1'b0, 32'hA000_0000);
    expect_hit("R6 c2 ext", 32'h5900_0008, 2'd2, 1'b1, 32'hB000_0008);
  endtask

  task automatic t_gaps_R7();
    expect_miss("R7 past ext", 32'h4E00_0000);
    expect_miss("R7 past last vp", 32'h5C00_0000);
    cfg_count = 2'd2;
    settle();
    expect_miss("R7 two ctrl", 32'h5800_0000);
    base_cfg();
    settle();
  endtask

  task automatic t_auto_R8();
    base_cfg();
    cfg_auto  = 1'b1;
    cfg_count = 2'd0;
    cfg_vp_size[31:0] = 32'h0300_0000;
    settle();
    check(win_size == 34'h0_1000_0000, "R8 size", 64'(win_size), 64'h1000_0000);
    check(!cfg_err, "R8 no err", 64'(cfg_err), 64'd0);
    expect_hit("R8 ext", 32'h4C00_0004, 2'd0, 1'b1, 32'h2000_0004);
    expect_miss("R8 single", 32'h5000_0000);
    base_cfg();
    settle();
  endtask

  task automatic t_cfgerr_R9();
    base_cfg();
    settle();
    check(!cfg_err, "R9 clean", 64'(cfg_err), 64'd0);
    cfg_vp_size[63:32] = 32'h0600_0000;
    settle();
    check(cfg_err, "R9 not pow2", 64'(cfg_err), 64'd1);
    cfg_vp_size[63:32] = 32'h0400_0000;
    settle();
    check(cfg_err, "R9 too small", 64'(cfg_err), 64'd1);
    base_cfg();
    cfg_count = 2'd0;
    settle();
    check(cfg_err, "R9 count", 64'(cfg_err), 64'd1);
    base_cfg();
    cfg_count = 2'd1;
    cfg_vp_size[95:64] = 32'h0000_0003;
    settle();
    check(!cfg_err, "R9 inactive ignored", 64'(cfg_err), 64'd0);
    base_cfg();
    settle();
  endtask

  task automatic t_hold_R10();
    lookup(32'h5000_0100);
    check(out_valid, "R10 valid", 64'(out_valid), 64'd1);
    in_addr = 32'h4000_0020;
    @(negedge clk);
    check(!out_valid && !out_hit && !out_miss, "R10 idle", 64'(out_valid), 64'd0);
    check(out_phys == 32'h9000_0100 && out_ctrl == 2'd1, "R10 hold",
          64'(out_phys), 64'h9000_0100);
  endtask

  initial begin
    t_reset_R1();
    t_size_R2();
    t_edges_R3();
    t_map_R4_R5_R6();
    t_gaps_R7();
    t_auto_R8();
    t_cfgerr_R9();
    t_hold_R10();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule